// File: doc/BRIEF.md
# Word-wide one-time-programmable memory with mode decoder

This block is a clocked, synthesizable model of a 16-bit-wide one-time-programmable memory as the device itself sees it. A chip-select, an output-gate and two voltage qualifiers are decoded into six operating modes: standby, programming lockout, programming, output off, array read and identifier read. The bidirectional data pins are split into an input word, an output word and an output-drive flag. A separate flag, `dq_valid`, marks the cycles in which the output word may be sampled.

Every cell starts erased at all ones. Programming can only clear bits: each program pulse ANDs the word on the data-in port into the stored word. Read latency is counted in clock cycles. An address-to-data delay and a shorter output-gate-to-data delay run side by side, and data become valid once both have elapsed. When a high-voltage flag is raised during a read, the array is replaced by a two-word identifier chosen by address bit 0.

Top module: `otp_word_rom`

## Requirements
- R1: After reset, `dq_oe` and `dq_valid` are 0, and every word that has never been programmed reads 0xFFFF.
- R2: In read mode (`ce_n`=0, `vpp_hi`=0, `oe_n`=0), `dq_valid` rises and `dq_out` shows the stored word at the later of two edges: the ACC_CYC-th consecutive rising edge that samples a stable address with `ce_n` low, and the OE_CYC-th consecutive rising edge that samples read mode. Before that edge `dq_valid` is 0. `dq_valid` is never 1 while `dq_oe` is 0.
- R3: Standby: every rising edge that samples `ce_n`=1 leaves `dq_oe`=0 and `dq_valid`=0, whatever the level of `oe_n`.
- R4: Output off: a rising edge that samples `ce_n`=0, `vpp_hi`=0 and `oe_n`=1 leaves `dq_oe`=0.
- R5: Programming: the first rising edge that samples `ce_n`=0 with `vpp_hi`=1, following an edge that sampled `ce_n`=1, stores (old word AND `dq_in`) at `addr`. Keeping `ce_n` low for further cycles writes nothing more. `dq_oe` stays 0.
- R6: Programming lockout: while `vpp_hi`=1 and `ce_n`=1, no word changes and `dq_oe` stays 0.
- R7: Identifier read: read mode with `id_hv`=1 returns 0x0020 when `addr[0]`=0 and 0x0034 when `addr[0]`=1. Bits 15:8 are 0 and the timing is that of R2.
- R8: Turn-off: the first rising edge that samples `oe_n`=1 or `ce_n`=1 clears `dq_oe` and `dq_valid` at once.
- R9: After an address change in read mode, `dq_valid` drops at the next edge. `dq_out` keeps the previous word until the new word becomes valid, ACC_CYC edges after the change.
- R10: Once a bit has been programmed to 0, programming a 1 into it leaves it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| vpp_hi | input | 1 | Programming voltage present on the output-gate pin |
| id_hv | input | 1 | High voltage present on the identifier address line |
| addr | input | AW | Word address |
| dq_in | input | 16 | Data pins as inputs (program word) |
| dq_out | output | 16 | Data pins as outputs |
| dq_oe | output | 1 | Output driver enable (0 = high impedance) |
| dq_valid | output | 1 | Output word is valid for sampling |

## Verification
The checks assume that inputs change only between clock edges, so each edge sees one settled combination of select, gate and qualifier levels. They also assume that `vpp_hi` is never raised while a read is in progress; the programming lockout assertion relies on this. The stimulus returns `ce_n` high before it touches `vpp_hi` or `id_hv`. During identifier reads it holds every address bit except bit 0 low. It leaves at least one idle cycle after each program pulse so that the deferred array write completes before the next read.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_PROGRAM,
    MD_DISABLE,
    MD_READ,
    MD_IDENT
  } otp_mode_e;

  localparam int          WORD_W   = 16;
  localparam int          ID_W     = 8;
  localparam logic [7:0]  ID_MAKER = 8'h20;
  localparam logic [7:0]  ID_PART  = 8'h34;

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      vpp_hi,
  input  logic      id_hv,
  output otp_mode_e mode,
  output logic      prog_stb
);

  logic ce_hi_q;

  always_comb begin
    if (ce_n)        mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    else if (vpp_hi) mode = MD_PROGRAM;
    else if (oe_n)   mode = MD_DISABLE;
    else if (id_hv)  mode = MD_IDENT;
    else             mode = MD_READ;
  end

  // one write per select pulse: only the first low sample after a high one
  always_ff @(posedge clk) begin
    if (rst) ce_hi_q <= 1'b1;
    else     ce_hi_q <= ce_n;
  end

  assign prog_stb = (mode == MD_PROGRAM) && ce_hi_q;

endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic          pend_v;
  logic [AW-1:0] pend_a;
  logic [DW-1:0] pend_d;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  // the strobe cycle reads the old word into rd_q; the following cycle
  // writes back old AND new through the single write port
  always_ff @(posedge clk) begin
    rd_q <= mem[rd_addr];
    if (pend_v) mem[pend_a] <= rd_q & pend_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      pend_d <= '1;
    end else begin
      pend_v <= wr_stb;
      if (wr_stb) begin
        pend_a <= wr_addr;
        pend_d <= wr_data;
      end
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/otp_timing.sv
module otp_timing
  import otp_pkg::*;
#(
  parameter int AW      = 10,
  parameter int ACC_CYC = 4,
  parameter int OE_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  otp_mode_e     mode,
  input  logic [AW-1:0] addr,
  input  logic          id_hv,
  output logic          drive_nx,
  output logic          valid_nx
);

  localparam int CW = $clog2(ACC_CYC + 1);
  localparam int OW = $clog2(OE_CYC + 1);

  logic [CW-1:0] acc_q, acc_nx;
  logic [OW-1:0] oe_q, oe_nx;
  logic [AW-1:0] addr_q;
  logic          id_q;
  logic          run, sel, chg;

  always_comb begin
    run = (mode == MD_READ) || (mode == MD_IDENT) || (mode == MD_DISABLE);
    sel = (mode == MD_READ) || (mode == MD_IDENT);
    chg = (addr != addr_q) || (id_hv != id_q);

    if (!run)                        acc_nx = '0;
    else if (chg)                    acc_nx = CW'(1);
    else if (acc_q == CW'(ACC_CYC))  acc_nx = acc_q;
    else                             acc_nx = acc_q + 1'b1;

    if (!sel)                        oe_nx = '0;
    else if (oe_q == OW'(OE_CYC))    oe_nx = oe_q;
    else                             oe_nx = oe_q + 1'b1;

    drive_nx = sel;
    valid_nx = sel && (acc_nx == CW'(ACC_CYC)) && (oe_nx == OW'(OE_CYC));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      oe_q   <= '0;
      addr_q <= '0;
      id_q   <= 1'b0;
    end else begin
      acc_q  <= acc_nx;
      oe_q   <= oe_nx;
      addr_q <= addr;
      id_q   <= id_hv;
    end
  end

endmodule

// File: rtl/otp_word_rom.sv
module otp_word_rom
  import otp_pkg::*;
#(
  parameter int AW      = 10,
  parameter int ACC_CYC = 4,
  parameter int OE_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              dq_valid
);

  otp_mode_e         mode;
  logic              prog_stb;
  logic              drive_nx, valid_nx;
  logic [WORD_W-1:0] arr_word, word;
  logic [ID_W-1:0]   id_code;

  otp_mode_dec u_dec (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .vpp_hi   (vpp_hi),
    .id_hv    (id_hv),
    .mode     (mode),
    .prog_stb (prog_stb)
  );

  otp_array #(.AW(AW), .DW(WORD_W)) u_arr (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (addr),
    .rd_data (arr_word),
    .wr_stb  (prog_stb),
    .wr_addr (addr),
    .wr_data (dq_in)
  );

  otp_timing #(.AW(AW), .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC)) u_tim (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .addr     (addr),
    .id_hv    (id_hv),
    .drive_nx (drive_nx),
    .valid_nx (valid_nx)
  );

  always_comb begin
    id_code = addr[0] ? ID_PART : ID_MAKER;
    if (mode == MD_IDENT) word = {{(WORD_W-ID_W){1'b0}}, id_code};
    else                  word = arr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe    <= 1'b0;
      dq_valid <= 1'b0;
      dq_out   <= '0;
    end else begin
      dq_oe    <= drive_nx;
      dq_valid <= valid_nx;
      if (!drive_nx)     dq_out <= '0;
      else if (valid_nx) dq_out <= word;
    end
  end

endmodule

// File: rtl/otp_word_rom_chk.sv
module otp_word_rom_chk (
  input logic        clk,
  input logic        rst,
  input logic        ce_n,
  input logic        oe_n,
  input logic        vpp_hi,
  input logic        id_hv,
  input logic [15:0] dq_out,
  input logic        dq_oe,
  input logic        dq_valid
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!dq_oe && !dq_valid)); // R1

  AST_VALID_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    dq_valid |-> dq_oe); // R2

  AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_valid) |-> $past(!ce_n && !oe_n && !vpp_hi)); // R2

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (!dq_oe && !dq_valid)); // R3

  AST_GATE_OFF_HIZ: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && oe_n && !vpp_hi) |=> (!dq_oe && !dq_valid)); // R4

  AST_PROG_HIZ: assert property (@(posedge clk) disable iff (rst)
    vpp_hi |=> !dq_oe); // R6

  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && !vpp_hi && id_hv) |=> (!dq_valid || dq_out[15:8] == 8'h00)); // R7

  AST_STALE_HELD: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && !dq_valid) |-> $stable(dq_out)); // R9

endmodule

bind otp_word_rom otp_word_rom_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .vpp_hi   (vpp_hi),
  .id_hv    (id_hv),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe),
  .dq_valid (dq_valid)
);

// File: tb/otp_word_rom_test.sv
`timescale 1ns/1ps
module otp_word_rom_test;

  localparam int AW  = 10;
  localparam int ACC = 4;
  localparam int OEC = 2;

  // {addr, program word, expected read-back}
  localparam logic [41:0] VEC [6] = '{
    {10'd3,    16'h1234, 16'h1234},
    {10'd4,    16'hF0F0, 16'hF0F0},
    {10'd3,    16'hFF00, 16'h1200},
    {10'd1023, 16'h0001, 16'h0001},
    {10'd4,    16'hFFFF, 16'hF0F0},
    {10'd0,    16'h8000, 16'h8000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   dq_in = '0;
  logic [15:0]   dq_out;
  logic          dq_oe, dq_valid;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  otp_word_rom #(.AW(AW), .ACC_CYC(ACC), .OE_CYC(OEC)) uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_hv(id_hv), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_valid(dq_valid)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic idv,
                    input logic [15:0] exp, input string req);
    addr = a; id_hv = idv; ce_n = 1'b0; oe_n = 1'b0;
    step(ACC - 1);
    chk({req, " R2 not early"}, {15'd0, dq_valid}, 16'd0);
    step(1);
    chk({req, " R2 valid"}, {15'd0, dq_valid}, 16'd1);
    chk({req, " data"}, dq_out, exp);
    ce_n = 1'b1; oe_n = 1'b1; id_hv = 1'b0;
    step(1);
    chk({req, " R8 off"}, {15'd0, dq_oe}, 16'd0);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
    addr = a; dq_in = d; vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    step(1);
    ce_n = 1'b0;
    step(1);
    chk("R5 no drive while programming", {15'd0, dq_oe}, 16'd0);
    dq_in = 16'h0000;  // a second write in this pulse would zero the word
    step(2);
    ce_n = 1'b1;
    step(1);
    vpp_hi = 1'b0;
    step(1);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 dq_oe after reset", {15'd0, dq_oe}, 16'd0);
    chk("R1 dq_valid after reset", {15'd0, dq_valid}, 16'd0);
    rd(10'd7, 1'b0, 16'hFFFF, "R1 erased word");

    // table: program then read back (R5, R10 on repeated addresses)
    for (int i = 0; i < 6; i++) begin
      prog(VEC[i][41:32], VEC[i][31:16]);
      rd(VEC[i][41:32], 1'b0, VEC[i][15:0], "R5/R10 table");
    end

    // R6: lockout with select high
    addr = 10'd5; dq_in = 16'h0000; vpp_hi = 1'b1; ce_n = 1'b1;
    step(3);
    chk("R6 no drive in lockout", {15'd0, dq_oe}, 16'd0);
    vpp_hi = 1'b0;
    step(1);
    rd(10'd5, 1'b0, 16'hFFFF, "R6 word untouched");

    // R7: identifier words
    rd(10'd0, 1'b1, 16'h0020, "R7 maker id");
    rd(10'd1, 1'b1, 16'h0034, "R7 part id");

    // R4 then R2 gate path: address settled, gate released later
    addr = 10'd3; ce_n = 1'b0; oe_n = 1'b1;
    step(6);
    chk("R4 gate off", {15'd0, dq_oe}, 16'd0);
    oe_n = 1'b0;
    step(OEC - 1);
    chk("R2 gate delay not early", {15'd0, dq_valid}, 16'd0);
    step(1);
    chk("R2 gate delay valid", {15'd0, dq_valid}, 16'd1);
    chk("R2 gate delay data", dq_out, 16'h1200);

    // R9: address change keeps the stale word
    addr = 10'd4;
    step(1);
    chk("R9 valid drops", {15'd0, dq_valid}, 16'd0);
    chk("R9 stale held", dq_out, 16'h1200);
    step(ACC - 2);
    chk("R9 still held", dq_out, 16'h1200);
    step(1);
    chk("R9 new valid", {15'd0, dq_valid}, 16'd1);
    chk("R9 new data", dq_out, 16'hF0F0);

    // R8: gate high turns drivers off in one edge
    oe_n = 1'b1;
    step(1);
    chk("R8 gate off", {15'd0, dq_oe}, 16'd0);
    chk("R8 valid off", {15'd0, dq_valid}, 16'd0);

    // R3: standby with gate low
    oe_n = 1'b0; ce_n = 1'b1;
    step(2);
    chk("R3 standby gate low", {15'd0, dq_oe}, 16'd0);
    chk("R3 standby valid", {15'd0, dq_valid}, 16'd0);
    oe_n = 1'b1;
    step(1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule